// File: doc/BRIEF.md
# Serial Character Receiver with Receive Queue

The receiver watches an asynchronous serial input line and recovers characters from it. It counts oversample ticks that an external baud generator supplies. A character starts when the line falls. Bits arrive least significant first and are sampled once near the middle of each bit. The character length and parity check follow a packed mode encoding, and the transmitter in the same chip uses the same encoding. The number of ticks per bit is programmable.

Each recovered character goes into a small receive queue. Software, or a bus adapter, reads the front entry and removes it with a one-cycle pop strobe. The receiver raises an empty flag whenever the queue holds nothing. A receive enable gates reception. A self-clearing soft-reset strobe empties the queue and clears the error flags. Three sticky error flags report a parity mismatch, a low stop bit, and a character lost because the queue was full.

Top module: `serial_rx_deframer`

## Requirements
- R1: After reset, rx_empty is 1 and err_parity, err_frame and err_overrun are all 0.
- R2: rx_empty (bit 1 of the status word) is 1 exactly when the queue holds no character. A pop while the queue is empty has no effect.
- R3: The character length comes from mode_len (mode bits [2:1]): 2'b11 gives 6 bits, 2'b10 gives 7 bits, and 2'b00 or 2'b01 gives 8 bits. Characters shorter than 8 bits are stored with zeros in the upper bits of rd_data.
- R4: Parity comes from mode_par (mode bits [5:3]). 3'b000 is even parity, meaning data plus parity bit hold an even number of ones. 3'b001 is odd parity. 3'b01x and 3'b1xx mean no parity bit.
- R5: One bit lasts bit_div+1 ticks, with bit_div at least 3. A frame begins on a falling edge of the line. The start bit must still be low at mid-bit, so a low pulse shorter than half a bit starts no character.
- R6: A received parity bit that does not match sets err_parity. The flag stays set until soft reset, and the character is still stored.
- R7: A stop bit sampled low sets err_frame. The flag stays set until soft reset, and the character is still stored.
- R8: A character that completes while the queue is full is discarded and sets err_overrun, which stays set until soft reset. The queued characters are left unchanged.
- R9: A one-cycle rx_soft_reset (control bit 0) flushes the queue and clears all three error flags on the next clock edge.
- R10: While rx_enable (control bit 2) is 0, line activity stores nothing and sets no flag.
- R11: Characters are read in arrival order. rd_data shows the oldest entry, and rd_pop removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversample tick from the baud generator, one cycle wide |
| rxd | input | 1 | Serial line, idle high |
| rx_enable | input | 1 | Receive enable (control bit 2) |
| rx_soft_reset | input | 1 | Self-clearing receive soft reset (control bit 0) |
| bit_div | input | DIV_W | Ticks per bit minus one |
| mode_len | input | 2 | Character length code (mode bits [2:1]) |
| mode_par | input | 3 | Parity code (mode bits [5:3]) |
| rd_pop | input | 1 | Removes the front character |
| rd_data | output | 8 | Front character, zero-extended |
| rx_empty | output | 1 | Queue empty (status bit 1) |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun |

## Verification
A fault in the bit counter or the mid-bit sample point does not show up as a hang. It shows up as a wrong character value, or as a false parity or framing flag. That becomes visible at rd_data and the flags about two clocks after the stop-bit sample. A fault in a queue pointer shows up as a wrong empty flag or the wrong front entry as soon as the next push or pop. A sticky flag that is lost, or a flush that is only partial, shows up on the first idle cycle after it happens. For this reason the outputs are compared against a queue model on every quiet cycle, not only at chosen points.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
   localparam int CHAR_W = 8;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_e;

   // index of the last data bit for a length code
   function automatic logic [2:0] last_bit_idx(input logic [1:0] len_code);
      case (len_code)
         2'b11:   last_bit_idx = 3'd5;
         2'b10:   last_bit_idx = 3'd6;
         default: last_bit_idx = 3'd7;
      endcase
   endfunction
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   generate
      if (STAGES == 0) begin : g_pass
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else if (STAGES == 1) chain[0] <= d_in;
            else chain <= {chain[STAGES-2:0], d_in};
         end
         assign d_out = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
   import serial_rx_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              os_tick,
   input  logic              rx_line,
   input  logic [DIV_W-1:0]  bit_div,
   input  logic [1:0]        mode_len,
   input  logic [2:0]        mode_par,
   output logic              chr_push,
   output logic [CHAR_W-1:0] chr_data,
   output logic              chr_perr,
   output logic              chr_ferr
);
   rx_state_e         state;
   logic [DIV_W-1:0]  cnt;
   logic [2:0]        bit_idx;
   logic [CHAR_W-1:0] shreg;
   logic              line_q;
   logic              par_acc;
   logic              perr_pend;
   logic              push_q;
   logic              perr_q;
   logic              ferr_q;
   logic [2:0]        last_idx;
   logic              par_on;
   logic              par_odd;
   logic              at_mid;
   logic              at_full;

   always_comb begin
      last_idx = last_bit_idx(mode_len);
      par_on   = (mode_par[2:1] == 2'b00);
      par_odd  = mode_par[0];
      at_mid   = (cnt == (bit_div >> 1));
      at_full  = (cnt == bit_div);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         cnt       <= '0;
         bit_idx   <= '0;
         shreg     <= '0;
         line_q    <= 1'b1;
         par_acc   <= 1'b0;
         perr_pend <= 1'b0;
         push_q    <= 1'b0;
         perr_q    <= 1'b0;
         ferr_q    <= 1'b0;
      end else begin
         push_q <= 1'b0;
         if (os_tick) line_q <= rx_line;
         if (clr) begin
            state <= RX_IDLE;
         end else if (os_tick) begin
            case (state)
               RX_IDLE: begin
                  if (line_q && !rx_line) begin
                     state <= RX_START;
                     cnt   <= '0;
                  end
               end
               RX_START: begin
                  if (at_mid) begin
                     cnt       <= '0;
                     bit_idx   <= '0;
                     shreg     <= '0;
                     par_acc   <= 1'b0;
                     perr_pend <= 1'b0;
                     state     <= rx_line ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (at_full) begin
                     cnt            <= '0;
                     shreg[bit_idx] <= rx_line;
                     par_acc        <= par_acc ^ rx_line;
                     if (bit_idx == last_idx) state <= par_on ? RX_PAR : RX_STOP;
                     else bit_idx <= bit_idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_PAR: begin
                  if (at_full) begin
                     cnt       <= '0;
                     perr_pend <= (rx_line != (par_acc ^ par_odd));
                     state     <= RX_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (at_full) begin
                     cnt    <= '0;
                     push_q <= 1'b1;
                     ferr_q <= !rx_line;
                     perr_q <= par_on && perr_pend;
                     state  <= RX_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   assign chr_push = push_q;
   assign chr_data = shreg;
   assign chr_perr = perr_q;
   assign chr_ferr = ferr_q;
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rd,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full
);
   localparam int AW = $clog2(DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW:0]      wp;
   logic [AW:0]      rp;

   assign empty = (wp == rp);
   assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign rdata = mem[rp[AW-1:0]];

   always_ff @(posedge clk) begin
      if (wr) mem[wp[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else if (clr) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (wr) wp <= wp + 1'b1;
         if (rd) rp <= rp + 1'b1;
      end
   end
endmodule

// File: rtl/serial_rx_deframer.sv
module serial_rx_deframer
   import serial_rx_pkg::*;
#(
   parameter int FIFO_DEPTH  = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              rxd,
   input  logic              rx_enable,
   input  logic              rx_soft_reset,
   input  logic [DIV_W-1:0]  bit_div,
   input  logic [1:0]        mode_len,
   input  logic [2:0]        mode_par,
   input  logic              rd_pop,
   output logic [CHAR_W-1:0] rd_data,
   output logic              rx_empty,
   output logic              err_parity,
   output logic              err_frame,
   output logic              err_overrun
);
   generate
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two of at least 2");
      end
      if (DIV_W < 2) begin : g_bad_div
         $error("DIV_W must be at least 2");
      end
   endgenerate

   logic              rx_line;
   logic              chr_push;
   logic [CHAR_W-1:0] chr_data;
   logic              chr_perr;
   logic              chr_ferr;
   logic              fifo_full;
   logic              fifo_empty;

   serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (rxd),
      .d_out (rx_line)
   );

   serial_rx_framer #(.DIV_W(DIV_W)) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (rx_soft_reset || !rx_enable),
      .os_tick  (os_tick),
      .rx_line  (rx_line),
      .bit_div  (bit_div),
      .mode_len (mode_len),
      .mode_par (mode_par),
      .chr_push (chr_push),
      .chr_data (chr_data),
      .chr_perr (chr_perr),
      .chr_ferr (chr_ferr)
   );

   serial_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(CHAR_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rx_soft_reset),
      .wr    (chr_push && !fifo_full && !rx_soft_reset),
      .wdata (chr_data),
      .rd    (rd_pop && !fifo_empty && !rx_soft_reset),
      .rdata (rd_data),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   assign rx_empty = fifo_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_parity  <= 1'b0;
         err_frame   <= 1'b0;
         err_overrun <= 1'b0;
      end else if (rx_soft_reset) begin
         err_parity  <= 1'b0;
         err_frame   <= 1'b0;
         err_overrun <= 1'b0;
      end else if (chr_push) begin
         if (fifo_full) err_overrun <= 1'b1;
         if (chr_perr)  err_parity  <= 1'b1;
         if (chr_ferr)  err_frame   <= 1'b1;
      end
   end
endmodule

// File: rtl/serial_rx_deframer_chk.sv
module serial_rx_deframer_chk (
   input logic clk,
   input logic rst_n,
   input logic rx_enable,
   input logic rx_soft_reset,
   input logic rx_empty,
   input logic err_parity,
   input logic err_frame,
   input logic err_overrun,
   input logic chr_push,
   input logic fifo_full
);
   a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rx_soft_reset |=> rx_empty && !err_parity && !err_frame && !err_overrun);

   a_r6_parity_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_parity && !rx_soft_reset |=> err_parity);

   a_r7_frame_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_frame && !rx_soft_reset |=> err_frame);

   a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_overrun && !rx_soft_reset |=> err_overrun);

   a_r8_full_push_flags: assert property (@(posedge clk) disable iff (!rst_n)
      chr_push && fifo_full && !rx_soft_reset |=> err_overrun);

   a_r2_pop_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
      rx_empty && !chr_push |=> rx_empty);

   a_r10_disabled_no_push: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enable |=> !chr_push);

   a_r2_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !rx_empty);
endmodule

bind serial_rx_deframer serial_rx_deframer_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rx_enable     (rx_enable),
   .rx_soft_reset (rx_soft_reset),
   .rx_empty      (rx_empty),
   .err_parity    (err_parity),
   .err_frame     (err_frame),
   .err_overrun   (err_overrun),
   .chr_push      (chr_push),
   .fifo_full     (fifo_full)
);

// File: tb/serial_rx_deframer_bench.sv
module serial_rx_deframer_bench;
   localparam int DEPTH = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       rxd = 1'b1;
   logic       rx_enable = 1'b1;
   logic       rx_soft_reset = 1'b0;
   logic [7:0] bit_div = 8'd7;
   logic [1:0] mode_len = 2'b00;
   logic [2:0] mode_par = 3'b100;
   logic       rd_pop = 1'b0;
   logic [7:0] rd_data;
   logic       rx_empty;
   logic       err_parity;
   logic       err_frame;
   logic       err_overrun;

   int   n_checks = 0;
   int   n_fail = 0;
   bit   chk_on = 1'b0;
   bit   done = 1'b0;
   string phase = "R1";

   logic [7:0] exp_q[$];
   bit exp_par = 1'b0;
   bit exp_frm = 1'b0;
   bit exp_ovr = 1'b0;

   serial_rx_deframer u_serial_rx_deframer (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
      .rx_enable(rx_enable), .rx_soft_reset(rx_soft_reset),
      .bit_div(bit_div), .mode_len(mode_len), .mode_par(mode_par),
      .rd_pop(rd_pop), .rd_data(rd_data), .rx_empty(rx_empty),
      .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun)
   );

   always #5 clk = ~clk;
   always @(posedge clk) os_tick <= ~os_tick;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   // per-cycle comparison against the queue model during quiet periods
   always @(negedge clk) begin
      if (chk_on && rst_n && !done) begin
         check({phase, " empty"}, rx_empty, exp_q.size() == 0);
         check({phase, " parity flag"}, err_parity, exp_par);
         check({phase, " frame flag"}, err_frame, exp_frm);
         check({phase, " overrun flag"}, err_overrun, exp_ovr);
         if (exp_q.size() != 0) check({phase, " head"}, rd_data, exp_q[0]);
      end
   end

   function automatic int nbits();
      case (mode_len)
         2'b11:   return 6;
         2'b10:   return 7;
         default: return 8;
      endcase
   endfunction

   task automatic send_frame(input logic [7:0] d, input bit bad_p, input bit bad_s);
      int bc = (int'(bit_div) + 1) * 2;
      int nb = nbits();
      bit has_par = (mode_par[2:1] == 2'b00);
      logic [7:0] m = 8'((1 << nb) - 1);
      logic pb = (^(d & m)) ^ mode_par[0] ^ bad_p;
      chk_on = 1'b0;
      rxd = 1'b0;
      repeat (bc) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         rxd = d[i];
         repeat (bc) @(negedge clk);
      end
      if (has_par) begin
         rxd = pb;
         repeat (bc) @(negedge clk);
      end
      rxd = !bad_s;
      repeat (bc) @(negedge clk);
      rxd = 1'b1;
      repeat (2 * bc) @(negedge clk);
      if (rx_enable) begin
         if (exp_q.size() >= DEPTH) exp_ovr = 1'b1;
         else exp_q.push_back(d & m);
         if (has_par && bad_p) exp_par = 1'b1;
         if (bad_s) exp_frm = 1'b1;
      end
      chk_on = 1'b1;
   endtask

   task automatic pop();
      @(negedge clk);
      rd_pop = 1'b1;
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) void'(exp_q.pop_front());
      rd_pop = 1'b0;
   endtask

   task automatic soft_reset();
      @(negedge clk);
      rx_soft_reset = 1'b1;
      @(posedge clk);
      #1;
      exp_q.delete();
      exp_par = 1'b0;
      exp_frm = 1'b0;
      exp_ovr = 1'b0;
      rx_soft_reset = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 empty", rx_empty, 1);
      check("R1 flags", {err_parity, err_frame, err_overrun}, 0);
      chk_on = 1'b1;

      // R11 order, 8 bits no parity
      phase = "R11";
      send_frame(8'hA5, 0, 0);
      send_frame(8'h3C, 0, 0);
      @(negedge clk); check("R11 first", rd_data, 8'hA5);
      pop();
      @(negedge clk); check("R11 second", rd_data, 8'h3C);
      pop();
      @(negedge clk); check("R2 empty after pops", rx_empty, 1);

      // R2 pop on empty ignored
      phase = "R2";
      pop();
      @(negedge clk); check("R2 pop empty", rx_empty, 1);
      send_frame(8'h81, 0, 0);
      @(negedge clk); check("R2 data after empty pop", rd_data, 8'h81);
      pop();

      // R3 and R4 lengths and parity
      phase = "R3";
      mode_len = 2'b10; mode_par = 3'b000;
      send_frame(8'hD5, 0, 0);
      @(negedge clk); check("R3 7-bit even", rd_data, 8'h55);
      check("R4 even ok", err_parity, 0);
      pop();
      mode_len = 2'b11; mode_par = 3'b001;
      send_frame(8'hFF, 0, 0);
      @(negedge clk); check("R3 6-bit zero ext", rd_data, 8'h3F);
      check("R4 odd ok", err_parity, 0);
      pop();
      phase = "R4";
      mode_len = 2'b01; mode_par = 3'b010;
      send_frame(8'hC3, 0, 0);
      @(negedge clk); check("R4 01x none / R3 8-bit", rd_data, 8'hC3);
      pop();

      // R5 other dividers and glitch rejection
      phase = "R5";
      mode_len = 2'b00; mode_par = 3'b100;
      bit_div = 8'd15;
      send_frame(8'h5A, 0, 0);
      @(negedge clk); check("R5 div 15", rd_data, 8'h5A);
      pop();
      bit_div = 8'd4;
      send_frame(8'h96, 0, 0);
      @(negedge clk); check("R5 div 4", rd_data, 8'h96);
      pop();
      bit_div = 8'd7;
      @(negedge clk); rxd = 1'b0;
      repeat (2) @(negedge clk); rxd = 1'b1;
      repeat (48) @(negedge clk);
      check("R5 glitch ignored", rx_empty, 1);

      // R6 parity error
      phase = "R6";
      mode_par = 3'b000;
      send_frame(8'h0F, 1, 0);
      @(negedge clk); check("R6 parity flag", err_parity, 1);
      check("R6 char kept", rd_data, 8'h0F);
      pop();
      send_frame(8'h11, 0, 0);
      @(negedge clk); check("R6 sticky", err_parity, 1);

      // R9 soft reset
      phase = "R9";
      soft_reset();
      @(negedge clk); check("R9 flushed", rx_empty, 1);
      check("R9 flags clear", {err_parity, err_frame, err_overrun}, 0);

      // R7 framing error
      phase = "R7";
      mode_par = 3'b100;
      send_frame(8'h77, 0, 1);
      @(negedge clk); check("R7 frame flag", err_frame, 1);
      check("R7 char kept", rd_data, 8'h77);
      pop();
      send_frame(8'h22, 0, 0);
      @(negedge clk); check("R7 sticky", err_frame, 1);
      soft_reset();

      // R8 overrun
      phase = "R8";
      bit_div = 8'd3;
      for (int k = 0; k < DEPTH; k++) send_frame(8'(8'h10 + k), 0, 0);
      @(negedge clk); check("R8 not yet", err_overrun, 0);
      send_frame(8'hEE, 0, 0);
      @(negedge clk); check("R8 overrun flag", err_overrun, 1);
      for (int k = 0; k < DEPTH; k++) begin
         @(negedge clk); check("R8 kept order", rd_data, 8'(8'h10 + k));
         pop();
      end
      @(negedge clk); check("R8 discarded", rx_empty, 1);
      soft_reset();

      // R10 receive disabled
      phase = "R10";
      bit_div = 8'd7;
      rx_enable = 1'b0;
      send_frame(8'h44, 0, 1);
      @(negedge clk); check("R10 nothing stored", rx_empty, 1);
      check("R10 no flag", err_frame, 0);
      rx_enable = 1'b1;
      repeat (4) @(negedge clk);
      send_frame(8'h45, 0, 0);
      @(negedge clk); check("R10 re-enabled", rd_data, 8'h45);

      chk_on = 1'b0;
      finish_run();
   end
endmodule